// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block collects event pulses from two timers (overflow, two compare matches per timer, and one input capture on the second timer) into a flag register. It holds a matching enable register and turns the pair into interrupt requests for a CPU. Software reaches both registers over a small register bus with a one-bit address. Reads return the register contents through combinational logic. Writes take effect at the next clock edge.

A flag clears in two ways. Software can write a one to it, or the CPU can acknowledge that source's vector with an encoded index. An event always sets its flag, whatever the enables say, so software can poll flags with interrupts off. A request is raised for a source only when the global interrupt enable, the source's enable bit and its flag are all one. A fixed-priority selector reports the lowest-numbered pending source as the active vector, next to a combined request line.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Both registers share one bit layout, and the bit index is also the event input bit, request bit and vector index.
    - Bit 0 is timer0 compare A, bit 1 is timer0 overflow and bit 2 is timer0 compare B.
    - Bit 3 is timer1 capture, bit 5 is timer1 compare B, bit 6 is timer1 compare A and bit 7 is timer1 overflow.
    - Bus address 0 selects the flag register and address 1 selects the enable register.
- R2: Bit 4 is reserved in both registers. It always reads as zero, and writes, events and acknowledges on it have no effect.
- R3: After reset, every bit of both registers reads zero and no request is raised.
- R4: An event pulse on a source sets that flag at the next clock edge, even when its enable bit or the global enable is zero.
- R5: A bus write to address 0 clears each flag whose write-data bit is one. Flags whose write-data bit is zero are left unchanged.
- R6: A cycle with `ack_valid` high clears only the flag selected by `ack_idx`, at the next clock edge.
- R7: When an event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: A bus write to address 1 replaces all implemented enable bits with the write data.
- R9: `irq_req[i]` is high exactly when `gie`, enable bit i and flag bit i are all one.
- R10: `irq_any` is the OR of all requests. `irq_vec` is the lowest index with a pending request, and it is 0 when none is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 flags, 1 enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| evt | input | 8 | Event pulses, one per flag bit |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_idx | input | 3 | Encoded index of the acknowledged source |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 8 | Per-source interrupt requests |
| irq_any | output | 1 | Combined request |
| irq_vec | output | 3 | Index of the highest-priority pending request |

## Verification
The bench builds the block with its default parameters: eight register bits, with bit 4 left unimplemented, and a three-bit acknowledge index. These values bring every source and the reserved position within reach, including an acknowledge aimed at the reserved index. Because all eight bits fit in one random word, a single stimulus can collide events with write-one clears and acknowledges on any bit. The same stimulus can also leave every request pending at once, which exercises the priority selector at both ends.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    // Register width: one bit per interrupt source position.
    localparam int unsigned TIRQ_NSRC = 8;

    // Implemented bit positions. Position 4 is reserved.
    localparam logic [TIRQ_NSRC-1:0] TIRQ_IMPL = 8'hEF;

    // Source positions. The numbering is also the priority order, lowest first.
    localparam int unsigned POS_T0_CMPA = 0;
    localparam int unsigned POS_T0_OVF  = 1;
    localparam int unsigned POS_T0_CMPB = 2;
    localparam int unsigned POS_T1_CAPT = 3;
    localparam int unsigned POS_RSVD    = 4;
    localparam int unsigned POS_T1_CMPB = 5;
    localparam int unsigned POS_T1_CMPA = 6;
    localparam int unsigned POS_T1_OVF  = 7;

    typedef enum logic {
        REGSEL_FLAG = 1'b0,
        REGSEL_ENAB = 1'b1
    } regsel_e;

endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
    parameter int unsigned     N    = 8,
    parameter logic [N-1:0]    IMPL = '1,
    localparam int unsigned    IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_wr,
    input  logic [N-1:0]  clr_data,
    input  logic [N-1:0]  evt,
    input  logic          ack_valid,
    input  logic [IW-1:0] ack_idx,
    output logic [N-1:0]  flags
);

    typedef struct packed {
        logic [N-1:0] flags;
    } flag_st_t;

    flag_st_t     st_d, st_q;
    logic [N-1:0] ack_mask;
    logic [N-1:0] wr_mask;
    logic [N-1:0] clr_all;

    always_comb begin
        ack_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (ack_valid && (ack_idx == IW'(i))) begin
                ack_mask[i] = 1'b1;
            end
        end
        wr_mask  = clr_wr ? clr_data : '0;
        clr_all  = wr_mask | ack_mask;
        st_d       = st_q;
        // Set dominates clear, so an event arriving with a clear is kept.
        st_d.flags = ((st_q.flags & ~clr_all) | evt) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/tmr_irq_mask.sv
module tmr_irq_mask #(
    parameter int unsigned  N    = 8,
    parameter logic [N-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] enables
);

    typedef struct packed {
        logic [N-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en = wdata & IMPL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enables = st_q.en;

endmodule

// File: rtl/tmr_irq_prio.sv
module tmr_irq_prio #(
    parameter int unsigned  N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] vec
);

    always_comb begin
        vec = '0;
        // Scan downward so the lowest pending index is the last one written.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                vec = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
#(
    parameter int unsigned     NSRC = TIRQ_NSRC,
    parameter logic [NSRC-1:0] IMPL = TIRQ_IMPL,
    localparam int unsigned    IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] evt,
    input  logic            ack_valid,
    input  logic [IW-1:0]   ack_idx,
    input  logic            gie,
    output logic [NSRC-1:0] irq_req,
    output logic            irq_any,
    output logic [IW-1:0]   irq_vec
);

    logic            wr_flag;
    logic            wr_enab;
    logic [NSRC-1:0] flag_q_w;
    logic [NSRC-1:0] enab_q_w;

    assign wr_flag = bus_wr && (regsel_e'(bus_addr) == REGSEL_FLAG);
    assign wr_enab = bus_wr && (regsel_e'(bus_addr) == REGSEL_ENAB);

    tmr_irq_flags #(.N(NSRC), .IMPL(IMPL)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_wr    (wr_flag),
        .clr_data  (bus_wdata),
        .evt       (evt),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .flags     (flag_q_w)
    );

    tmr_irq_mask #(.N(NSRC), .IMPL(IMPL)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_enab),
        .wdata   (bus_wdata),
        .enables (enab_q_w)
    );

    always_comb begin
        bus_rdata = (regsel_e'(bus_addr) == REGSEL_ENAB) ? enab_q_w : flag_q_w;
        irq_req   = flag_q_w & enab_q_w & {NSRC{gie}};
    end

    tmr_irq_prio #(.N(NSRC)) u_prio (
        .req (irq_req),
        .any (irq_any),
        .vec (irq_vec)
    );

endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
    parameter int unsigned  NSRC = 8,
    parameter logic [NSRC-1:0] IMPL = '1,
    localparam int unsigned IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            gie,
    input logic [NSRC-1:0] evt,
    input logic            ack_valid,
    input logic [IW-1:0]   ack_idx,
    input logic [NSRC-1:0] flag_q_w,
    input logic [NSRC-1:0] bus_rdata,
    input logic [NSRC-1:0] irq_req,
    input logic            irq_any,
    input logic [IW-1:0]   irq_vec
);

    localparam logic [NSRC-1:0] ONE = NSRC'(1);

    p_rsvd_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL) == '0);

    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & IMPL)) |=> ((flag_q_w & $past(evt & IMPL)) == $past(evt & IMPL)));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !evt[ack_idx]) |=> !flag_q_w[$past(ack_idx)]);

    p_req_needs_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> gie);

    p_req_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~flag_q_w) == '0);

    p_vec_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (irq_req[irq_vec] && ((irq_req & ((ONE << irq_vec) - ONE)) == '0)));

    p_vec_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_any |-> (irq_vec == '0 && irq_req == '0));

endmodule

bind tmr_irq_ctrl tmr_irq_chk #(.NSRC(NSRC), .IMPL(IMPL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie),
    .evt       (evt),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .flag_q_w  (flag_q_w),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .irq_any   (irq_any),
    .irq_vec   (irq_vec)
);

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;

    localparam logic [7:0] IMPL_B = 8'hEF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] evt = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       gie = 1'b0;
    logic [7:0] irq_req;
    logic       irq_any;
    logic [2:0] irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] flags_m = '0;
    logic [7:0] mask_m  = '0;

    always #5 clk = ~clk;

    tmr_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .gie       (gie),
        .irq_req   (irq_req),
        .irq_any   (irq_any),
        .irq_vec   (irq_vec)
    );

    function automatic logic [7:0] next_flags(logic [7:0] f, logic wrf, logic [7:0] wd,
                                              logic [7:0] ev, logic av, logic [2:0] ai);
        logic [7:0] clr;
        clr = wrf ? wd : 8'h00;
        if (av) clr[ai] = 1'b1;
        return ((f & ~clr) | ev) & IMPL_B;
    endfunction

    function automatic logic [2:0] lowest(logic [7:0] r);
        for (int i = 0; i < 8; i++) if (r[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        logic [7:0] rq;
        rq = flags_m & mask_m & {8{gie}};
        chk({tag, " R9 irq_req"}, irq_req, rq);
        chk({tag, " R10 irq_any"}, {7'd0, irq_any}, {7'd0, |rq});
        chk({tag, " R10 irq_vec"}, {5'd0, irq_vec}, {5'd0, lowest(rq)});
        bus_addr = 1'b0;
        #1;
        chk({tag, " R1 flag read"}, bus_rdata, flags_m);
        bus_addr = 1'b1;
        #1;
        chk({tag, " R8 enable read"}, bus_rdata, mask_m);
        bus_addr = 1'b0;
    endtask

    task automatic step(string tag, logic wr, logic ad, logic [7:0] wd,
                        logic [7:0] ev, logic av, logic [2:0] ai);
        @(negedge clk);
        bus_wr = wr; bus_addr = ad; bus_wdata = wd;
        evt = ev; ack_valid = av; ack_idx = ai;
        flags_m = next_flags(flags_m, wr && !ad, wd, ev, av, ai);
        if (wr && ad) mask_m = wd & IMPL_B;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; evt = '0; ack_valid = 1'b0; bus_wdata = '0;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D4C);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3: reset state
        check_all("R3 reset");

        // R8 and R2: enable write replaces, reserved bit dropped
        step("R8 R2 enable write", 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 3'd0);
        chk("R2 enable bit4", {7'd0, mask_m[4]}, 8'h00);

        // R1: each event position lands on the same bit
        for (int i = 0; i < 8; i++) begin
            step("R1 single event", 1'b0, 1'b0, 8'h00, 8'(1) << i, 1'b0, 3'd0);
            step("R1 clear back", 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 3'd0);
        end

        // R4 and R9: events set flags with gie low, no request
        gie = 1'b0;
        step("R4 events gie off", 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 3'd0);
        chk("R4 all flags", flags_m, 8'hEF);
        step("R8 enables off", 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0);
        gie = 1'b1;
        #1;
        check_all("R9 enables off gie on");
        step("R8 enables on", 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 3'd0);
        chk("R10 vec all pending", {5'd0, irq_vec}, 8'h00);

        // R6: acknowledge clears one flag only; reserved index has no effect
        step("R6 ack 0", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 3'd0);
        chk("R6 after ack 0", flags_m, 8'hEE);
        step("R6 R2 ack 4", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 3'd4);
        chk("R6 R2 after ack 4", flags_m, 8'hEE);

        // R5: zero write keeps, one write clears
        step("R5 write zero", 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0);
        step("R5 write ones", 1'b1, 1'b0, 8'h06, 8'h00, 1'b0, 3'd0);
        chk("R5 after clear", flags_m, 8'hE8);

        // R7: set wins over clear
        step("R7 wr clear vs event", 1'b1, 1'b0, 8'h80, 8'h80, 1'b0, 3'd0);
        chk("R7 bit7 kept", {7'd0, flags_m[7]}, 8'h01);
        step("R7 ack vs event", 1'b0, 1'b0, 8'h00, 8'h08, 1'b1, 3'd3);
        chk("R7 bit3 kept", {7'd0, flags_m[3]}, 8'h01);

        // R10: highest index alone
        step("R10 clear all", 1'b1, 1'b0, 8'hFF, 8'h80, 1'b0, 3'd0);
        chk("R10 vec top", {5'd0, irq_vec}, 8'h07);

        // Random mix of all operations
        for (int n = 0; n < 400; n++) begin
            logic       wr, ad, av;
            logic [7:0] wd, ev;
            logic [2:0] ai;
            wr = ($urandom % 3) == 0;
            ad = $urandom % 2;
            wd = 8'($urandom);
            ev = 8'($urandom) & 8'($urandom);
            av = ($urandom % 3) == 0;
            ai = 3'($urandom);
            gie = ($urandom % 4) != 0;
            step("R4 R5 R6 R7 random", wr, ad, wd, ev, av, ai);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule